// File: doc/BRIEF.md
# PHY Control-Register Access Bridge

This block gives a host processor indirect access to the 16-bit internal control registers of a PHY. The host sees a few 32-bit registers in a memory-mapped window. To reach a PHY register, the host first places a value in a staging register. It then sets the trigger bit of one of four command registers. The bridge turns each trigger into one request on a PHY-side control bus and holds that request until the PHY answers with a single acknowledge pulse. The trigger bit reads back as 1 for as long as the request is open and returns to 0 once it has been acknowledged. Host software can therefore poll the trigger bit to learn when a command has finished.

A PHY write takes five host writes:

1. Put the PHY address in the staging register.
2. Trigger address capture.
3. Put the value in the staging register.
4. Trigger data capture.
5. Trigger the write.

A PHY read takes three host writes:

1. Put the PHY address in the staging register.
2. Trigger address capture.
3. Trigger the read.

The host then collects the result from the result register. Lane-specific PHY addresses are computed by software as a base plus 0x100 times the lane number. The bridge passes the full 16-bit address through unchanged.

The sequencer is a five-state machine:

- **ST_IDLE**: no request is open.
- **ST_CAPA**: address-capture request open.
- **ST_CAPD**: data-capture request open.
- **ST_READ**: read request open.
- **ST_WRITE**: write request open.

Its transitions are:

- **launch**: ST_IDLE moves to one command state on a host write of 1 to that command's trigger bit.
- **complete**: any command state returns to ST_IDLE on the clock edge that samples phy_ack high.
- **hold**: a command state stays put while phy_ack is low.

Top module: `phy_cr_bridge`

## Requirements
- R1: After reset, all four trigger bits read 0 and all four PHY requests are low. phy_addr and phy_wdata are 0, and the result register (offset 0x10) reads 0.
- R2: A host write to the staging register (offset 0x0C) stores bits 15:0, and reading offset 0x0C returns them with bits 31:16 zero. Bits 31:1 of every trigger register read 0. Every offset outside 0x0C, 0x10, 0x14, 0x18, 0x1C and 0x20 reads 0.
- R3: Writing 1 to bit 0 of offset 0x14 while idle has two effects from the next cycle onward. phy_cap_addr goes high with phy_addr equal to the staged value, and bit 0 of 0x14 reads 1. Both stay so until the edge that samples phy_ack high, and from the next cycle both are 0.
- R4: Writing 1 to bit 0 of offset 0x18 while idle latches the staged value into the captured data. phy_cap_data is then raised with phy_wdata equal to that value, held until acknowledged, and bit 0 of 0x18 mirrors the request.
- R5: Writing 1 to bit 0 of offset 0x20 while idle raises phy_wr until acknowledged, with phy_addr and phy_wdata holding the captured address and data. Bit 0 of 0x20 mirrors the request.
- R6: Writing 1 to bit 0 of offset 0x1C while idle raises phy_rd with the captured address until acknowledged. The result register (0x10) then takes phy_rdata as sampled on the acknowledging edge, in bits 15:0 with bits 31:16 zero.
- R7: At most one of phy_cap_addr, phy_cap_data, phy_rd and phy_wr is high in any cycle.
- R8: A trigger written while another command is open is ignored. Its bit reads 0, and no request for it is raised after the open command completes.
- R9: The result register keeps its value until the next read is acknowledged. Capture and write commands do not change it.
- R10: While a command is open, rewriting the staging register does not change phy_addr or phy_wdata. Writing 0 to bit 0 of a trigger register starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host write enable for this cycle |
| host_addr | input | 8 | Host byte offset (write and read) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, combinational from host_addr |
| phy_addr | output | 16 | Captured PHY register address |
| phy_wdata | output | 16 | Captured PHY write data |
| phy_rdata | input | 16 | PHY read data, valid with phy_ack during a read |
| phy_cap_addr | output | 1 | Address-capture request |
| phy_cap_data | output | 1 | Data-capture request |
| phy_rd | output | 1 | Read request |
| phy_wr | output | 1 | Write request |
| phy_ack | input | 1 | Single-cycle acknowledge from the PHY |

## Verification
The bench builds the bridge with its default parameters:

- a 32-bit host data path;
- 16-bit PHY address and data;
- an 8-bit host offset.

These defaults put the whole 16-bit PHY address space within reach, including the lane-stepped addresses 0x1002, 0x1006, 0x1102 and 0x1306. The bench's PHY model acknowledges after a random delay of zero to several cycles. This exercises both zero-wait completion and long holds, which are the windows in which busy-time triggers and staging rewrites must be ignored.

// File: rtl/phy_cr_bridge_pkg.sv
package phy_cr_bridge_pkg;

    localparam int OFF_W = 8;

    localparam logic [OFF_W-1:0] OFF_DIN  = 8'h0C;
    localparam logic [OFF_W-1:0] OFF_DOUT = 8'h10;
    localparam logic [OFF_W-1:0] OFF_CAPA = 8'h14;
    localparam logic [OFF_W-1:0] OFF_CAPD = 8'h18;
    localparam logic [OFF_W-1:0] OFF_READ = 8'h1C;
    localparam logic [OFF_W-1:0] OFF_WRIT = 8'h20;

    localparam int NCMD = 4;

    // command index into request / busy vectors
    localparam int CMD_CAPA = 0;
    localparam int CMD_CAPD = 1;
    localparam int CMD_READ = 2;
    localparam int CMD_WRIT = 3;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CAPA  = 3'd1,
        ST_CAPD  = 3'd2,
        ST_READ  = 3'd3,
        ST_WRITE = 3'd4
    } seq_state_t;

    function automatic logic [OFF_W-1:0] cmd_offset(input int idx);
        unique case (idx)
            CMD_CAPA: cmd_offset = OFF_CAPA;
            CMD_CAPD: cmd_offset = OFF_CAPD;
            CMD_READ: cmd_offset = OFF_READ;
            default:  cmd_offset = OFF_WRIT;
        endcase
    endfunction

endpackage

// File: rtl/phy_cr_bridge_regs.sv
module phy_cr_bridge_regs
    import phy_cr_bridge_pkg::*;
#(
    parameter int HOST_DW = 32,
    parameter int HOST_AW = 8,
    parameter int PHY_DW  = 16,
    parameter int PHY_AW  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_wr,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [HOST_DW-1:0] host_wdata,
    output logic [HOST_DW-1:0] host_rdata,
    output logic [NCMD-1:0]    cmd_req,
    input  logic [NCMD-1:0]    launch,
    input  logic [NCMD-1:0]    busy_vec,
    input  logic               rd_done,
    input  logic [PHY_DW-1:0]  phy_rdata,
    output logic [PHY_AW-1:0]  addr_q,
    output logic [PHY_DW-1:0]  data_q,
    output logic [PHY_DW-1:0]  dout_q
);

    localparam int STAGE_W = (PHY_AW > PHY_DW) ? PHY_AW : PHY_DW;

    logic [STAGE_W-1:0] din_q;
    logic               din_we;
    logic               unused_wdata;

    assign din_we       = host_wr && (host_addr == HOST_AW'(OFF_DIN));
    assign unused_wdata = ^host_wdata[HOST_DW-1:STAGE_W];

    genvar gi;
    generate
        for (gi = 0; gi < NCMD; gi++) begin : g_req
            assign cmd_req[gi] = host_wr && host_wdata[0]
                              && (host_addr == HOST_AW'(cmd_offset(gi)));
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            din_q  <= '0;
            addr_q <= '0;
            data_q <= '0;
            dout_q <= '0;
        end else begin
            if (din_we)
                din_q <= host_wdata[STAGE_W-1:0];
            if (launch[CMD_CAPA])
                addr_q <= din_q[PHY_AW-1:0];
            if (launch[CMD_CAPD])
                data_q <= din_q[PHY_DW-1:0];
            if (rd_done)
                dout_q <= phy_rdata;
        end
    end

    always_comb begin
        host_rdata = '0;
        unique case (host_addr)
            HOST_AW'(OFF_DIN):  host_rdata[STAGE_W-1:0] = din_q;
            HOST_AW'(OFF_DOUT): host_rdata[PHY_DW-1:0]  = dout_q;
            HOST_AW'(OFF_CAPA): host_rdata[0] = busy_vec[CMD_CAPA];
            HOST_AW'(OFF_CAPD): host_rdata[0] = busy_vec[CMD_CAPD];
            HOST_AW'(OFF_READ): host_rdata[0] = busy_vec[CMD_READ];
            HOST_AW'(OFF_WRIT): host_rdata[0] = busy_vec[CMD_WRIT];
            default:            host_rdata = '0;
        endcase
    end

endmodule

// File: rtl/phy_cr_bridge_seq.sv
module phy_cr_bridge_seq
    import phy_cr_bridge_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCMD-1:0] cmd_req,
    input  logic            phy_ack,
    output logic [NCMD-1:0] launch,
    output logic [NCMD-1:0] busy_vec,
    output logic            rd_done
);

    seq_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_req[CMD_CAPA])      state_d = ST_CAPA;
                else if (cmd_req[CMD_CAPD]) state_d = ST_CAPD;
                else if (cmd_req[CMD_READ]) state_d = ST_READ;
                else if (cmd_req[CMD_WRIT]) state_d = ST_WRITE;
            end
            ST_CAPA, ST_CAPD, ST_READ, ST_WRITE: begin
                if (phy_ack) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        launch   = '0;
        busy_vec = '0;
        rd_done  = 1'b0;
        unique case (state_q)
            ST_IDLE:  launch = cmd_req;
            ST_CAPA:  busy_vec[CMD_CAPA] = 1'b1;
            ST_CAPD:  busy_vec[CMD_CAPD] = 1'b1;
            ST_READ: begin
                busy_vec[CMD_READ] = 1'b1;
                rd_done            = phy_ack;
            end
            ST_WRITE: busy_vec[CMD_WRIT] = 1'b1;
            default:  launch = '0;
        endcase
    end

endmodule

// File: rtl/phy_cr_bridge.sv
module phy_cr_bridge
    import phy_cr_bridge_pkg::*;
#(
    parameter int HOST_DW = 32,
    parameter int HOST_AW = 8,
    parameter int PHY_DW  = 16,
    parameter int PHY_AW  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_wr,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [HOST_DW-1:0] host_wdata,
    output logic [HOST_DW-1:0] host_rdata,
    output logic [PHY_AW-1:0]  phy_addr,
    output logic [PHY_DW-1:0]  phy_wdata,
    input  logic [PHY_DW-1:0]  phy_rdata,
    output logic               phy_cap_addr,
    output logic               phy_cap_data,
    output logic               phy_rd,
    output logic               phy_wr,
    input  logic               phy_ack
);

    logic [NCMD-1:0]   cmd_req;
    logic [NCMD-1:0]   launch;
    logic [NCMD-1:0]   busy_vec;
    logic              rd_done;
    logic [PHY_DW-1:0] dout_q;

    phy_cr_bridge_regs #(
        .HOST_DW (HOST_DW),
        .HOST_AW (HOST_AW),
        .PHY_DW  (PHY_DW),
        .PHY_AW  (PHY_AW)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .cmd_req    (cmd_req),
        .launch     (launch),
        .busy_vec   (busy_vec),
        .rd_done    (rd_done),
        .phy_rdata  (phy_rdata),
        .addr_q     (phy_addr),
        .data_q     (phy_wdata),
        .dout_q     (dout_q)
    );

    phy_cr_bridge_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_req  (cmd_req),
        .phy_ack  (phy_ack),
        .launch   (launch),
        .busy_vec (busy_vec),
        .rd_done  (rd_done)
    );

    assign phy_cap_addr = busy_vec[CMD_CAPA];
    assign phy_cap_data = busy_vec[CMD_CAPD];
    assign phy_rd       = busy_vec[CMD_READ];
    assign phy_wr       = busy_vec[CMD_WRIT];

endmodule

// File: rtl/phy_cr_bridge_chk.sv
module phy_cr_bridge_chk #(
    parameter int PHY_DW = 16,
    parameter int PHY_AW = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PHY_AW-1:0] phy_addr,
    input logic [PHY_DW-1:0] phy_wdata,
    input logic [PHY_DW-1:0] phy_rdata,
    input logic              phy_cap_addr,
    input logic              phy_cap_data,
    input logic              phy_rd,
    input logic              phy_wr,
    input logic              phy_ack,
    input logic [PHY_DW-1:0] dout_q
);

    logic any_req;
    assign any_req = phy_cap_addr | phy_cap_data | phy_rd | phy_wr;

    a_r7_one_request: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({phy_cap_addr, phy_cap_data, phy_rd, phy_wr}));

    a_r3_hold_capa: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_cap_addr && !phy_ack) |=> phy_cap_addr);

    a_r4_hold_capd: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_cap_data && !phy_ack) |=> phy_cap_data);

    a_r5_hold_wr: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_wr && !phy_ack) |=> phy_wr);

    a_r6_hold_rd: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_rd && !phy_ack) |=> phy_rd);

    a_r3_release: assert property (@(posedge clk) disable iff (!rst_n)
        (any_req && phy_ack) |=> !any_req);

    a_r10_bus_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (any_req && !phy_ack) |=> ($stable(phy_addr) && $stable(phy_wdata)));

    a_r6_result: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_rd && phy_ack) |=> (dout_q == $past(phy_rdata)));

    a_r9_keep: assert property (@(posedge clk) disable iff (!rst_n)
        !(phy_rd && phy_ack) |=> $stable(dout_q));

endmodule

bind phy_cr_bridge phy_cr_bridge_chk #(
    .PHY_DW (PHY_DW),
    .PHY_AW (PHY_AW)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .phy_addr     (phy_addr),
    .phy_wdata    (phy_wdata),
    .phy_rdata    (phy_rdata),
    .phy_cap_addr (phy_cap_addr),
    .phy_cap_data (phy_cap_data),
    .phy_rd       (phy_rd),
    .phy_wr       (phy_wr),
    .phy_ack      (phy_ack),
    .dout_q       (dout_q)
);

// File: tb/tb_phy_cr_bridge.sv
`timescale 1ns/1ps
module tb_phy_cr_bridge;

    localparam logic [7:0] A_DIN  = 8'h0C;
    localparam logic [7:0] A_DOUT = 8'h10;
    localparam logic [7:0] A_CAPA = 8'h14;
    localparam logic [7:0] A_CAPD = 8'h18;
    localparam logic [7:0] A_READ = 8'h1C;
    localparam logic [7:0] A_WRIT = 8'h20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [7:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic [15:0] phy_addr, phy_wdata;
    logic [15:0] phy_rdata = 16'hDEAD;
    logic        phy_cap_addr, phy_cap_data, phy_rd, phy_wr;
    logic        phy_ack = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    int lat = 0;
    int cnt = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    int cyc = 0;
    logic [15:0] pmem [256];
    logic [15:0] emem [256];

    always #5 clk = ~clk;

    phy_cr_bridge dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .phy_addr(phy_addr), .phy_wdata(phy_wdata), .phy_rdata(phy_rdata),
        .phy_cap_addr(phy_cap_addr), .phy_cap_data(phy_cap_data),
        .phy_rd(phy_rd), .phy_wr(phy_wr), .phy_ack(phy_ack)
    );

    function automatic int midx(input logic [15:0] a);
        return {a[9:8], a[5:0]};
    endfunction

    // PHY register-array model: acknowledges after lat cycles
    always @(negedge clk) begin
        if (phy_ack) begin
            phy_ack   = 1'b0;
            phy_rdata = 16'hDEAD;
            cnt       = 0;
        end else if (phy_cap_addr | phy_cap_data | phy_rd | phy_wr) begin
            if (cnt >= lat) begin
                phy_ack = 1'b1;
                if (phy_wr) begin
                    pmem[midx(phy_addr)] = phy_wdata;
                    wr_cnt++;
                end
                if (phy_rd) begin
                    phy_rdata = pmem[midx(phy_addr)];
                    rd_cnt++;
                end
            end else begin
                cnt++;
            end
        end
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
            summary();
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic hwrite(input logic [7:0] a, input logic [31:0] d);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hread(input logic [7:0] a, output logic [31:0] d);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic wait_idle(input logic [7:0] a, input string req);
        logic [31:0] v;
        int tries = 0;
        hread(a, v);
        while (v[0] && tries < 40) begin
            @(negedge clk);
            tries++;
            hread(a, v);
        end
        check(req, v, 32'h0);
    endtask

    task automatic phy_write(input logic [15:0] a, input logic [15:0] v);
        hwrite(A_DIN, {16'h0, a});
        hwrite(A_CAPA, 32'h1);
        wait_idle(A_CAPA, "R3 capa done");
        hwrite(A_DIN, {16'h0, v});
        hwrite(A_CAPD, 32'h1);
        wait_idle(A_CAPD, "R4 capd done");
        hwrite(A_WRIT, 32'h1);
        wait_idle(A_WRIT, "R5 write done");
        emem[midx(a)] = v;
    endtask

    task automatic phy_read(input logic [15:0] a, output logic [31:0] r);
        hwrite(A_DIN, {16'h0, a});
        hwrite(A_CAPA, 32'h1);
        wait_idle(A_CAPA, "R3 capa done");
        hwrite(A_READ, 32'h1);
        wait_idle(A_READ, "R6 read done");
        hread(A_DOUT, r);
    endtask

    initial begin
        logic [31:0] v;
        int rc0, wc0;
        void'($urandom(32'h1F2E3D4C));
        for (int i = 0; i < 256; i++) begin
            pmem[i] = '0;
            emem[i] = '0;
        end
        repeat (3) @(negedge clk);

        // R1 reset state
        check("R1 capa req", {31'h0, phy_cap_addr}, 32'h0);
        check("R1 rd|wr|capd", {29'h0, phy_rd, phy_wr, phy_cap_data}, 32'h0);
        hread(A_DOUT, v);  check("R1 dout", v, 32'h0);
        hread(A_READ, v);  check("R1 read strobe", v, 32'h0);
        check("R1 bus", {phy_addr, phy_wdata}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 staging and decode
        hwrite(A_DIN, 32'hABCD_1234);
        hread(A_DIN, v);   check("R2 din readback", v, 32'h0000_1234);
        hread(8'h24, v);   check("R2 unmapped", v, 32'h0);
        hread(8'h00, v);   check("R2 unmapped low", v, 32'h0);

        // R10 zero trigger starts nothing
        hwrite(A_CAPA, 32'hFFFF_FFFE);
        check("R10 zero trigger", {31'h0, phy_cap_addr}, 32'h0);

        // R3 capture address with long hold, R8 busy trigger, R10 staging rewrite
        lat = 6;
        hwrite(A_DIN, 32'h0000_1006);
        hwrite(A_CAPA, 32'h1);
        check("R3 capa raised", {31'h0, phy_cap_addr}, 32'h1);
        check("R3 phy_addr", {16'h0, phy_addr}, 32'h1006);
        hread(A_CAPA, v);  check("R3 capa strobe busy", v, 32'h1);
        hread(A_CAPA, v);  check("R2 strobe upper zero", v & 32'hFFFF_FFFE, 32'h0);
        rc0 = rd_cnt;
        hwrite(A_READ, 32'h1);
        hread(A_READ, v);  check("R8 busy read ignored", v, 32'h0);
        hwrite(A_DIN, 32'h0000_5555);
        check("R10 addr kept", {16'h0, phy_addr}, 32'h1006);
        wait_idle(A_CAPA, "R3 capa done");
        repeat (3) @(negedge clk);
        check("R8 no later rd", {31'h0, phy_rd}, 32'h0);
        check("R8 rd count", rd_cnt, rc0);
        check("R3 addr after", {16'h0, phy_addr}, 32'h1006);

        // R4 capture data, R5 write
        lat = 2;
        hwrite(A_DIN, 32'h0000_00A7);
        hwrite(A_CAPD, 32'h1);
        check("R4 capd raised", {31'h0, phy_cap_data}, 32'h1);
        check("R4 phy_wdata", {16'h0, phy_wdata}, 32'h00A7);
        hread(A_CAPD, v);  check("R4 capd strobe", v, 32'h1);
        wait_idle(A_CAPD, "R4 capd done");
        wc0 = wr_cnt;
        hwrite(A_WRIT, 32'h1);
        check("R5 wr raised", {31'h0, phy_wr}, 32'h1);
        check("R5 addr data", {phy_addr, phy_wdata}, {16'h1006, 16'h00A7});
        wait_idle(A_WRIT, "R5 write done");
        check("R5 one write", wr_cnt, wc0 + 1);
        emem[midx(16'h1006)] = 16'h00A7;

        // R6 read back, zero-latency ack
        lat = 0;
        phy_read(16'h1006, v);
        check("R6 read 0x1006", v, 32'h0000_00A7);

        // R9 capture and write leave dout alone
        phy_write(16'h1102, 16'hBEEF);
        hread(A_DOUT, v);  check("R9 dout kept", v, 32'h0000_00A7);

        // lane-stepped addresses
        phy_write(16'h1002, 16'h1111);
        phy_write(16'h1306, 16'h3333);
        phy_read(16'h1002, v);  check("R6 lane0", v, 32'h1111);
        phy_read(16'h1306, v);  check("R6 lane3", v, 32'h3333);
        phy_read(16'h1102, v);  check("R6 lane1", v, 32'hBEEF);

        // random traffic
        for (int k = 0; k < 40; k++) begin
            logic [15:0] a;
            logic [15:0] d;
            a = 16'h1000 + 16'(($urandom % 4) * 256) + 16'($urandom % 64);
            d = 16'($urandom);
            lat = int'($urandom % 5);
            if ($urandom % 2) begin
                phy_write(a, d);
            end else begin
                phy_read(a, v);
                check("R6 random read", v, {16'h0, emem[midx(a)]});
            end
        end

        // R7 idle after traffic
        check("R7 all idle", {28'h0, phy_cap_addr, phy_cap_data, phy_rd, phy_wr}, 32'h0);
        summary();
    end

endmodule